// File: doc/BRIEF.md
# Dual-Width BCD Arithmetic Unit

This block is the accumulator arithmetic stage of a 16-bit processor that can also run with an 8-bit accumulator. From a decoded operation, a width select, the decimal-mode flag, the incoming carry and overflow flags, the current register value and the memory operand, it computes the new register value and the C, Z, V and N flags. Addition with carry and subtraction with borrow run in either plain binary or packed BCD, where every nibble is corrected in turn. The unit also performs compares against whichever register the caller presents, a bit test against the accumulator, and the three logical operations.

The caller holds `op_valid` high for one cycle with all inputs stable. The result and flags are registered on that clock edge and `res_valid` pulses for that one cycle. Between strobes the outputs hold their last value. In 8-bit mode only the low byte takes part in the operation, and the upper byte of the register passes through unchanged.

Top module: `dwbcd_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_out` becomes 0, all four flags become 0 and `res_valid` becomes 0.
- R2: An op sampled with `op_valid` high at a clock edge appears on `res_out` and the flags right after that edge, and `res_valid` is high for exactly that cycle. With `op_valid` low, every output holds and `res_valid` is low.
- R3: Operation codes on `op_code`: 0 add with carry, 1 subtract with borrow, 2 compare, 3 bit test, 4 AND, 5 OR, 6 XOR, 7 pass (the register is unchanged, C and V pass through, Z and N come from the register). With `dec_mode` low, add returns A+M+C and sets C when the sum reaches 2^width.
- R4: With `dec_mode` low, subtract returns A-M-(1-C) and sets C when that difference is not negative.
- R5: With `dec_mode` high, add works digit by digit from the lowest nibble up. Each nibble sum includes the carry from the nibble below. A sum above 9 has 10 taken off, is cut to four bits and carries into the next nibble. C is the carry out of the top active nibble.
- R6: With `dec_mode` high, subtract takes each operand nibble from the register nibble, with a borrow of NOT C on the lowest nibble. From the low nibble upwards, a nibble that went negative gets 10 added, is cut to four bits and borrows from the next nibble. C is cleared when the top active nibble went negative and set otherwise.
- R7: V for add is set when both inputs share a sign bit that differs from the result's sign bit. V for subtract is set when the input signs differ and the result sign differs from the register's. In decimal mode the result used is the corrected one.
- R8: With `wide` low (8-bit mode), only bits 7:0 are operated on and flagged. Bits 15:8 of `res_out` equal bits 15:8 of `reg_in` for every operation.
- R9: Z is set exactly when the result at the active width is zero, and N is its most significant bit.
- R10: Compare forms register minus operand with no carry-in, in binary even when `dec_mode` is high. It sets C when register >= operand, sets Z and N from the difference, leaves V at `ovf_in`, and returns `reg_in` unchanged.
- R11: Bit test sets Z when (register AND operand) is zero at the active width. N takes the operand's top active bit and V the bit just below it, C stays at `carry_in`, and the register is returned unchanged.
- R12: AND, OR and XOR write the logical result at the active width, set Z and N from it, and leave C and V at `carry_in` and `ovf_in`.
- R13: In decimal mode, nibbles holding 10 to 15 go through the same correction rules with no special handling. For example, 8-bit add of 0x0F and 0x01 with C=0 gives 0x16 with C=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe that launches an operation |
| op_code | input | 3 | Operation code, encoded as in R3 |
| wide | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| dec_mode | input | 1 | Decimal flag; selects BCD for add and subtract |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| reg_in | input | 16 | Register value (accumulator, or the index register for compare) |
| mem_in | input | 16 | Memory operand |
| res_out | output | 16 | New register value |
| res_valid | output | 1 | High in the cycle after an accepted strobe |
| flag_c | output | 1 | Carry flag out |
| flag_z | output | 1 | Zero flag out |
| flag_v | output | 1 | Overflow flag out |
| flag_n | output | 1 | Negative flag out |

## Verification
Every result, flag and `res_valid` is due one register stage after the strobe. The bench drives a strobe at a falling edge and drops it at the next falling edge, so the capture edge lies between the two. It reads the outputs at that second falling edge and never on a rising edge. A hold case then holds the strobe low for several cycles while the inputs change, and confirms that the outputs stay fixed and `res_valid` stays low.

// File: rtl/dwbcd_pkg.sv
package dwbcd_pkg;

    typedef enum logic [2:0] {
        OP_ADC = 3'd0,
        OP_SBC = 3'd1,
        OP_CMP = 3'd2,
        OP_BIT = 3'd3,
        OP_AND = 3'd4,
        OP_ORA = 3'd5,
        OP_EOR = 3'd6,
        OP_NOP = 3'd7
    } op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic v;
        logic n;
    } flags_t;

    typedef struct packed {
        logic [3:0] digit;
        logic       link;   // carry out (add) or borrow out (sub)
    } nib_t;

    // One decimal digit of an add: correct sums above nine.
    function automatic nib_t nib_add(input logic [3:0] a, input logic [3:0] m,
                                     input logic ci);
        nib_t       r;
        logic [4:0] s;
        s = {1'b0, a} + {1'b0, m} + {4'b0, ci};
        if (s > 5'd9) begin
            r.digit = s[3:0] - 4'd10;
            r.link  = 1'b1;
        end else begin
            r.digit = s[3:0];
            r.link  = 1'b0;
        end
        return r;
    endfunction

    // One decimal digit of a subtract: correct digits that went negative.
    function automatic nib_t nib_sub(input logic [3:0] a, input logic [3:0] m,
                                     input logic bi);
        nib_t       r;
        logic [5:0] d;
        d = {2'b0, a} - {2'b0, m} - {5'b0, bi};
        if (d[5]) begin
            r.digit = d[3:0] + 4'd10;
            r.link  = 1'b1;
        end else begin
            r.digit = d[3:0];
            r.link  = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/dwbcd_decimal.sv
module dwbcd_decimal
    import dwbcd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic              carry_in,
    input  logic              sub,
    input  logic              wide,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out
);
    localparam int NIB  = DATA_W / 4;
    localparam int HNIB = NIB / 2;

    logic [NIB:0]      add_link;
    logic [NIB:0]      sub_link;
    logic [DATA_W-1:0] add_sum;
    logic [DATA_W-1:0] sub_sum;

    assign add_link[0] = carry_in;
    assign sub_link[0] = ~carry_in;

    for (genvar i = 0; i < NIB; i++) begin : g_digit
        nib_t ra;
        nib_t rs;
        always_comb begin
            ra = nib_add(a[4*i +: 4], m[4*i +: 4], add_link[i]);
            rs = nib_sub(a[4*i +: 4], m[4*i +: 4], sub_link[i]);
        end
        assign add_sum[4*i +: 4] = ra.digit;
        assign sub_sum[4*i +: 4] = rs.digit;
        assign add_link[i+1]     = ra.link;
        assign sub_link[i+1]     = rs.link;
    end

    always_comb begin
        sum = sub ? sub_sum : add_sum;
        if (sub)
            carry_out = wide ? ~sub_link[NIB] : ~sub_link[HNIB];
        else
            carry_out = wide ? add_link[NIB] : add_link[HNIB];
    end

endmodule

// File: rtl/dwbcd_binary.sv
module dwbcd_binary #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic              carry_in,
    input  logic              sub,
    input  logic              cmp,
    input  logic              wide,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] m_eff;
    logic              cin;
    logic [DATA_W:0]   full;
    logic [HALF:0]     part;

    always_comb begin
        m_eff = sub ? ~m : m;
        cin   = cmp ? 1'b1 : carry_in;
        full  = {1'b0, a} + {1'b0, m_eff} + {{DATA_W{1'b0}}, cin};
        part  = {1'b0, a[HALF-1:0]} + {1'b0, m_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
        if (wide) begin
            sum       = full[DATA_W-1:0];
            carry_out = full[DATA_W];
        end else begin
            sum       = {a[DATA_W-1:HALF], part[HALF-1:0]};
            carry_out = part[HALF];
        end
    end

endmodule

// File: rtl/dwbcd_combine.sv
module dwbcd_combine
    import dwbcd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic              wide,
    input  logic              dec_mode,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic [DATA_W-1:0] reg_in,
    input  logic [DATA_W-1:0] mem_in,
    input  logic [DATA_W-1:0] dec_sum,
    input  logic              dec_c,
    input  logic [DATA_W-1:0] bin_sum,
    input  logic              bin_c,
    output logic [DATA_W-1:0] res,
    output flags_t            flags
);
    localparam int HALF = DATA_W / 2;

    function automatic logic top_bit(input logic [DATA_W-1:0] x, input logic w);
        return w ? x[DATA_W-1] : x[HALF-1];
    endfunction

    function automatic logic is_zero(input logic [DATA_W-1:0] x, input logic w);
        return w ? (x == '0) : (x[HALF-1:0] == '0);
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] keep,
                                                input logic [DATA_W-1:0] x,
                                                input logic w);
        return w ? x : {keep[DATA_W-1:HALF], x[HALF-1:0]};
    endfunction

    logic [DATA_W-1:0] arith;
    logic [DATA_W-1:0] logic_r;
    logic [DATA_W-1:0] zn_src;
    logic              a_t, m_t, r_t;

    always_comb begin
        arith = dec_mode ? dec_sum : bin_sum;
        a_t   = top_bit(reg_in, wide);
        m_t   = top_bit(mem_in, wide);
        r_t   = top_bit(arith, wide);

        case (op)
            OP_AND:  logic_r = reg_in & mem_in;
            OP_ORA:  logic_r = reg_in | mem_in;
            default: logic_r = reg_in ^ mem_in;
        endcase

        res     = reg_in;
        zn_src  = reg_in;
        flags.c = carry_in;
        flags.v = ovf_in;
        flags.z = 1'b0;
        flags.n = 1'b0;

        case (op)
            OP_ADC: begin
                res     = merge(reg_in, arith, wide);
                zn_src  = res;
                flags.c = dec_mode ? dec_c : bin_c;
                flags.v = (a_t == m_t) && (r_t != m_t);
            end
            OP_SBC: begin
                res     = merge(reg_in, arith, wide);
                zn_src  = res;
                flags.c = dec_mode ? dec_c : bin_c;
                flags.v = (a_t != m_t) && (r_t != a_t);
            end
            OP_CMP: begin
                zn_src  = bin_sum;
                flags.c = bin_c;
            end
            OP_BIT: begin
                zn_src = reg_in & mem_in;
            end
            OP_AND, OP_ORA, OP_EOR: begin
                res    = merge(reg_in, logic_r, wide);
                zn_src = res;
            end
            default: begin
                zn_src = reg_in;
            end
        endcase

        flags.z = is_zero(zn_src, wide);
        if (op == OP_BIT) begin
            flags.n = m_t;
            flags.v = wide ? mem_in[DATA_W-2] : mem_in[HALF-2];
        end else begin
            flags.n = top_bit(zn_src, wide);
        end
    end

endmodule

// File: rtl/dwbcd_alu.sv
module dwbcd_alu
    import dwbcd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              wide,
    input  logic              dec_mode,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic [DATA_W-1:0] reg_in,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] res_out,
    output logic              res_valid,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_n
);
    localparam int HALF = DATA_W / 2;

    op_e               op;
    logic [DATA_W-1:0] dec_sum, bin_sum, nxt_res;
    logic              dec_c, bin_c;
    flags_t            nxt_flags, flags_q;

    assign op = op_e'(op_code);

    dwbcd_decimal #(.DATA_W(DATA_W)) u_dec (
        .a(reg_in), .m(mem_in), .carry_in(carry_in),
        .sub(op == OP_SBC), .wide(wide),
        .sum(dec_sum), .carry_out(dec_c)
    );

    dwbcd_binary #(.DATA_W(DATA_W)) u_bin (
        .a(reg_in), .m(mem_in), .carry_in(carry_in),
        .sub((op == OP_SBC) || (op == OP_CMP)), .cmp(op == OP_CMP),
        .wide(wide), .sum(bin_sum), .carry_out(bin_c)
    );

    dwbcd_combine #(.DATA_W(DATA_W)) u_comb (
        .op(op), .wide(wide), .dec_mode(dec_mode), .carry_in(carry_in),
        .ovf_in(ovf_in), .reg_in(reg_in), .mem_in(mem_in),
        .dec_sum(dec_sum), .dec_c(dec_c), .bin_sum(bin_sum), .bin_c(bin_c),
        .res(nxt_res), .flags(nxt_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out   <= '0;
            flags_q   <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_out <= nxt_res;
                flags_q <= nxt_flags;
            end
        end
    end

    assign flag_c = flags_q.c;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_n = flags_q.n;

    // R2
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(res_out) && $stable(flags_q)));

    // R8
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !wide) |=> (res_out[DATA_W-1:HALF] == $past(reg_in[DATA_W-1:HALF])));

    // R10
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CMP) |=> (res_out == $past(reg_in)));

    // R9
    logic_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_AND || op_code == OP_ORA || op_code == OP_EOR))
        |=> (flag_z == ($past(wide) ? (res_out == '0) : (res_out[HALF-1:0] == '0))));

    // R11
    bit_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_BIT)
        |=> (flag_n == ($past(wide) ? $past(mem_in[DATA_W-1]) : $past(mem_in[HALF-1]))));

endmodule

// File: tb/dwbcd_alu_test.sv
module dwbcd_alu_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic        wide, dec_mode, carry_in, ovf_in;
    logic [15:0] reg_in, mem_in;
    logic [15:0] res_out;
    logic        res_valid, flag_c, flag_z, flag_v, flag_n;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwbcd_alu uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .wide(wide), .dec_mode(dec_mode), .carry_in(carry_in), .ovf_in(ovf_in),
        .reg_in(reg_in), .mem_in(mem_in), .res_out(res_out), .res_valid(res_valid),
        .flag_c(flag_c), .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
    );

    // Compare {res, valid, c, z, v, n}
    task automatic check(input string tag, input logic [15:0] er,
                         input logic ev, input logic [3:0] ef);
        logic [20:0] got, exp;
        got = {res_out, res_valid, flag_c, flag_z, flag_v, flag_n};
        exp = {er, ev, ef};
        tests++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: actual res=%h valid=%b czvn=%b expected res=%h valid=%b czvn=%b",
                     tag, got[20:5], got[4], got[3:0], exp[20:5], exp[4], exp[3:0]);
        end
    endtask

    // Drive one strobe at a falling edge; outputs are read one falling edge later.
    task automatic run_op(input logic [2:0] op, input logic w, input logic d,
                          input logic c, input logic v,
                          input logic [15:0] r, input logic [15:0] m);
        @(negedge clk);
        op_code = op; wide = w; dec_mode = d; carry_in = c; ovf_in = v;
        reg_in = r; mem_in = m; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; op_valid = 1'b0; op_code = 3'd0; wide = 1'b1; dec_mode = 1'b0;
        carry_in = 1'b1; ovf_in = 1'b1; reg_in = 16'hFFFF; mem_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R1 reset", 16'h0000, 1'b0, 4'b0000);
        rst = 1'b0;
    endtask

    task automatic t_bin_add;
        run_op(3'd0, 1, 0, 0, 0, 16'h7FFF, 16'h0001);
        check("R3/R7 bin add overflow", 16'h8000, 1, 4'b0011);
        run_op(3'd0, 1, 0, 0, 1, 16'hFFFF, 16'h0001);
        check("R3 bin add wrap carry", 16'h0000, 1, 4'b1100);
        run_op(3'd0, 0, 0, 0, 0, 16'h33FF, 16'h0001);
        check("R3/R8 bin add 8-bit carry", 16'h3300, 1, 4'b1100);
    endtask

    task automatic t_bin_sub;
        run_op(3'd1, 1, 0, 1, 0, 16'h0005, 16'h0007);
        check("R4 bin sub negative", 16'hFFFE, 1, 4'b0001);
        run_op(3'd1, 1, 0, 0, 0, 16'h0010, 16'h0001);
        check("R4 bin sub borrow in", 16'h000E, 1, 4'b1000);
        run_op(3'd1, 1, 0, 1, 0, 16'h8000, 16'h0001);
        check("R4/R7 bin sub overflow", 16'h7FFF, 1, 4'b1010);
    endtask

    task automatic t_dec_add;
        run_op(3'd0, 1, 1, 0, 0, 16'h1234, 16'h5678);
        check("R5 dec add 16-bit", 16'h6912, 1, 4'b0000);
        run_op(3'd0, 1, 1, 0, 1, 16'h9999, 16'h0001);
        check("R5 dec add top carry", 16'h0000, 1, 4'b1100);
        run_op(3'd0, 0, 1, 1, 0, 16'hAB58, 16'h0046);
        check("R5/R8 dec add 8-bit", 16'hAB05, 1, 4'b1000);
        run_op(3'd0, 0, 1, 0, 0, 16'h0079, 16'h0010);
        check("R7 dec add overflow on corrected", 16'h0089, 1, 4'b0011);
    endtask

    task automatic t_dec_sub;
        run_op(3'd1, 1, 1, 1, 0, 16'h1000, 16'h0001);
        check("R6 dec sub ripple borrow", 16'h0999, 1, 4'b1000);
        run_op(3'd1, 0, 1, 1, 0, 16'h1200, 16'h0001);
        check("R6/R8 dec sub 8-bit underflow", 16'h1299, 1, 4'b0001);
        run_op(3'd1, 0, 1, 0, 0, 16'h0050, 16'h0025);
        check("R6 dec sub borrow in", 16'h0024, 1, 4'b1000);
    endtask

    task automatic t_bad_digits;
        run_op(3'd0, 0, 1, 0, 0, 16'h000F, 16'h0001);
        check("R13 dec add digit F", 16'h0016, 1, 4'b0000);
        run_op(3'd1, 0, 1, 1, 0, 16'h000A, 16'h0000);
        check("R13 dec sub digit A", 16'h000A, 1, 4'b1000);
    endtask

    task automatic t_compare;
        run_op(3'd2, 1, 0, 0, 1, 16'h1234, 16'h1234);
        check("R10 cmp equal", 16'h1234, 1, 4'b1110);
        run_op(3'd2, 0, 0, 1, 0, 16'hFF10, 16'h0020);
        check("R10/R8 cmp less 8-bit", 16'hFF10, 1, 4'b0001);
        run_op(3'd2, 1, 1, 0, 0, 16'h0009, 16'h0001);
        check("R10 cmp binary in dec mode", 16'h0009, 1, 4'b1000);
    endtask

    task automatic t_bit_test;
        run_op(3'd3, 1, 0, 1, 0, 16'h00FF, 16'hC000);
        check("R11 bit 16-bit", 16'h00FF, 1, 4'b1111);
        run_op(3'd3, 0, 0, 0, 0, 16'h0001, 16'h0041);
        check("R11 bit 8-bit", 16'h0001, 1, 4'b0010);
    endtask

    task automatic t_logic;
        run_op(3'd4, 1, 0, 1, 1, 16'hF0F0, 16'h0F0F);
        check("R12/R9 and zero", 16'h0000, 1, 4'b1110);
        run_op(3'd5, 0, 0, 0, 0, 16'h5500, 16'h0080);
        check("R12/R8 or 8-bit", 16'h5580, 1, 4'b0001);
        run_op(3'd6, 1, 0, 0, 1, 16'hFFFF, 16'h7FFF);
        check("R12/R9 xor negative", 16'h8000, 1, 4'b0011);
        run_op(3'd7, 1, 0, 1, 0, 16'h0000, 16'h1234);
        check("R3 pass op", 16'h0000, 1, 4'b1100);
    endtask

    task automatic t_hold;
        run_op(3'd0, 1, 0, 0, 0, 16'h0001, 16'h0002);
        check("R2 strobe result", 16'h0003, 1, 4'b0000);
        reg_in = 16'h8888; mem_in = 16'h7777; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 idle hold", 16'h0003, 0, 4'b0000);
    endtask

    initial begin
        t_reset;
        t_bin_add;
        t_bin_sub;
        t_dec_add;
        t_dec_sub;
        t_bad_digits;
        t_compare;
        t_bit_test;
        t_logic;
        t_hold;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule